// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit Rewind

This block is a FIFO whose write side and read side run on separate clocks. It has a fall-through output: the oldest stored word sits on the read data port, with a valid flag, before any read request. A read strobe consumes that word and shows the next one. Both sides derive a half-full flag, an almost-empty flag and an almost-full flag, with the thresholds set by parameters.

A retransmit strobe, sampled on the read clock, sends the read pointer back to address zero. Address zero is where the first word after reset was stored, so the whole packet written since reset can be read out again. Accepting the strobe starts a setup sequence of fixed length. During setup the output is invalid and read strobes have no effect. Writes are refused from shortly after the strobe until the replayed first word is shown, or until a fixed number of write-clock cycles have passed, whichever happens first. Each status flag is frozen during setup and refreshed on its own schedule afterwards, because the pointer jump has to settle across the clock boundary first.

The user must write no more than depth minus two words between reset and a retransmit. Under that rule the write-ready output stays high for the whole setup.

Top module: `rr_fifo`

## Requirements
- R1: A word written into an empty FIFO appears on `rd_data` with `rd_valid` high (1 = word present) without any read strobe. A read strobe while `rd_valid` is high consumes the word, and the words come out in the order they were written.
- R2: A read strobe while the FIFO is empty has no effect. When the write-side count reaches the depth (2**AW), `wr_ready` goes low (0 = no space) and write strobes are dropped. The word held on the output is not part of that count, so the block holds 2**AW + 1 words.
- R3: A high `rt_req` on a read-clock rising edge starts setup only if no setup is running. From that edge `rd_valid` is low and read strobes are ignored until setup ends. A further `rt_req` during setup is ignored.
- R4: Setup ends on the SETUP_CYC-th read-clock edge after the accepting edge. On that same edge, if any word has been stored, `rd_valid` goes high and `rd_data` shows the word at address zero, with no read strobe.
- R5: After setup, each further word of the replay needs a read strobe, and the words come out in their original write order starting from address zero.
- R6: `half_full` (1 when the read-side count is greater than 2**(AW-1)) holds its value through setup and takes the rewound count on the final setup edge.
- R7: `almost_empty` (1 when the read-side count is at most AE_OFF) holds its value through setup and for one edge after it, and takes the rewound count two read-clock edges after the final setup edge.
- R8: `almost_full` (1 when the write-side count is at least 2**AW - AF_OFF) is frozen while setup is seen on the write clock. It takes the rewound count on the third write-clock edge after the final setup edge: two edges to carry the state across, one to refresh the flag.
- R9: Write strobes are dropped from the third write-clock edge after the accepting edge. Writes resume once the replayed first word has been shown and that news has crossed to the write clock, or on the RELEASE_CYC-th write-clock edge after the accepting edge, whichever comes first.
- R10: With no more than depth minus two words written since reset, `wr_ready` stays high throughout setup.
- R11: Outside setup, the flags follow their thresholds. The read-side count includes the word held on the output; the write-side count excludes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain |
| wr_en | input | 1 | Write strobe, 1 = store `wr_data` |
| wr_data | input | DW | Write data |
| wr_ready | output | 1 | 1 = space available |
| almost_full | output | 1 | Write-side almost-full flag |
| rd_en | input | 1 | Read strobe, 1 = consume the shown word |
| rt_req | input | 1 | Retransmit strobe, sampled on `rclk` |
| rd_data | output | DW | Fall-through output word |
| rd_valid | output | 1 | 1 = `rd_data` holds a word |
| half_full | output | 1 | Read-side half-full flag |
| almost_empty | output | 1 | Read-side almost-empty flag |

## Verification
The bench targets the edges of the setup window. A second retransmit strobe in mid-setup would restart the sequence and push the replayed word one edge late. A write strobe inside the window would slip an extra word into the replay. Each flag is sampled on the edges just before and just after its own refresh point, so a design that refreshed a flag early would show the rewound count too soon and one that forgot to refresh it would never show it. A retransmit on an empty FIFO never produces a shown word, so it checks that the write-side timeout alone releases writes on the right edge.

// File: rtl/rr_fifo_pkg.sv
package rr_fifo_pkg;
  typedef enum logic {RT_IDLE = 1'b0, RT_SETUP = 1'b1} rt_state_e;
endpackage

// File: rtl/rr_sync.sv
module rr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rr_wr_side.sv
module rr_wr_side #(
  parameter int AW          = 4,
  parameter int AF_OFF      = 3,
  parameter int RELEASE_CYC = 14
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  input  logic          busy_s,
  input  logic          hold_s,
  output logic [AW-1:0] waddr,
  output logic          wr_do,
  output logic [AW:0]   wgray,
  output logic          wr_ready,
  output logic          almost_full
);
  localparam int          DEPTH    = 1 << AW;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] AF_LIM   = (AW+1)'(DEPTH - AF_OFF);
  localparam int          GW       = $clog2(RELEASE_CYC + 1);
  localparam logic [GW-1:0] RELOAD = GW'(RELEASE_CYC - 4);

  logic [AW:0]   wptr, wptr_n, rbin, count;
  logic [AW:0]   wgray_n;
  logic          hold_q, rise, block, full, af_n;
  logic [GW-1:0] gcnt, gcnt_n;

  always_comb begin
    for (int i = 0; i <= AW; i++) rbin[i] = ^(rgray_s >> i);
  end

  assign count    = wptr - rbin;
  assign full     = (count == FULL_CNT);
  assign rise     = hold_s && !hold_q;
  assign block    = hold_s && (rise || (gcnt != '0));
  assign wr_do    = wr_en && !full && !block;
  assign waddr    = wptr[AW-1:0];
  assign wr_ready = !full;

  always_comb begin
    wptr_n  = wptr + {{AW{1'b0}}, wr_do};
    wgray_n = wptr_n ^ (wptr_n >> 1);
    gcnt_n  = gcnt;
    if (rise)                       gcnt_n = RELOAD;
    else if (block && gcnt != '0)   gcnt_n = gcnt - GW'(1);
    af_n = busy_s ? almost_full : (count >= AF_LIM);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wptr        <= '0;
      wgray       <= '0;
      hold_q      <= 1'b0;
      gcnt        <= '0;
      almost_full <= 1'b0;
    end else begin
      wptr        <= wptr_n;
      wgray       <= wgray_n;
      hold_q      <= hold_s;
      gcnt        <= gcnt_n;
      almost_full <= af_n;
    end
  end

  // R2: the write pointer never runs more than a full depth ahead of the read side
  p_ptr_gap_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wptr - rbin) <= FULL_CNT);
  // R8: almost-full frozen while setup is visible on this clock
  p_af_hold_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
    busy_s |=> $stable(almost_full));
  // R9: inside the counted window no write moves the pointer
  p_block_window_r9: assert property (@(posedge wclk) disable iff (!wrst_n)
    (hold_s && hold_q && gcnt != '0) |=> $stable(wptr));
endmodule

// File: rtl/rr_rd_side.sv
module rr_rd_side
  import rr_fifo_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter int AE_OFF    = 2,
  parameter int SETUP_CYC = 4
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  input  logic          rt_req,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          half_full,
  output logic          almost_empty,
  output logic          busy,
  output logic          hold
);
  localparam int          DEPTH  = 1 << AW;
  localparam logic [AW:0] HALF   = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0] AE_LIM = (AW+1)'(AE_OFF);
  localparam int          CW     = $clog2(SETUP_CYC + 1);
  localparam logic [AW:0] ONE    = (AW+1)'(1);

  rt_state_e     state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [AW:0]   rptr, rptr_n, wbin, occ, rgray_n;
  logic          valid_n, hf_n, ae_n, hold_n, empty, load;
  logic [DW-1:0] dout_n;
  logic [1:0]    pc, pc_n;

  always_comb begin
    for (int i = 0; i <= AW; i++) wbin[i] = ^(wgray_s >> i);
  end

  assign empty = (wbin == rptr);
  assign occ   = wbin - rptr + {{AW{1'b0}}, rd_valid};
  assign load  = !empty && (!rd_valid || rd_en);
  assign raddr = rptr[AW-1:0];
  assign busy  = (state == RT_SETUP);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    rptr_n  = rptr;
    valid_n = rd_valid;
    dout_n  = rd_data;
    hf_n    = half_full;
    ae_n    = almost_empty;
    pc_n    = pc;
    hold_n  = hold;
    if (state == RT_IDLE && rt_req) begin
      state_n = RT_SETUP;
      cnt_n   = CW'(SETUP_CYC - 1);
      rptr_n  = '0;
      valid_n = 1'b0;
      hold_n  = 1'b1;
    end else if (state == RT_SETUP) begin
      if (cnt == '0) begin
        state_n = RT_IDLE;
        hf_n    = (wbin > HALF);
        pc_n    = 2'd2;
        if (wbin != '0) begin
          dout_n  = mem_q;
          rptr_n  = ONE;
          valid_n = 1'b1;
        end
      end else begin
        cnt_n = cnt - CW'(1);
      end
    end else begin
      if (load) begin
        dout_n  = mem_q;
        rptr_n  = rptr + ONE;
        valid_n = 1'b1;
      end else if (rd_en) begin
        valid_n = 1'b0;
      end
      hf_n = (occ > HALF);
      if (pc != 2'd2) ae_n = (occ <= AE_LIM);
      if (pc != 2'd0) pc_n = pc - 2'd1;
      if (rd_valid) hold_n = 1'b0;
    end
    rgray_n = rptr_n ^ (rptr_n >> 1);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      state        <= RT_IDLE;
      cnt          <= '0;
      rptr         <= '0;
      rgray        <= '0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      half_full    <= 1'b0;
      almost_empty <= 1'b1;
      pc           <= 2'd0;
      hold         <= 1'b0;
    end else begin
      state        <= state_n;
      cnt          <= cnt_n;
      rptr         <= rptr_n;
      rgray        <= rgray_n;
      rd_valid     <= valid_n;
      rd_data      <= dout_n;
      half_full    <= hf_n;
      almost_empty <= ae_n;
      pc           <= pc_n;
      hold         <= hold_n;
    end
  end

  // R2: an empty FIFO in normal operation never shows a word
  p_empty_no_valid_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!rd_valid && empty && state == RT_IDLE) |=> !rd_valid);
  // R3: no word is shown while setup runs
  p_setup_quiet_r3: assert property (@(posedge rclk) disable iff (!rrst_n)
    (state == RT_SETUP) |-> !rd_valid);
  // R4: final setup edge shows address zero and steps past it
  p_final_word_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    (state == RT_SETUP && cnt == '0 && wbin != '0) |=> (rd_valid && rptr == ONE));
  // R6: half-full held inside setup
  p_hf_hold_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
    (state == RT_SETUP && cnt != '0) |=> $stable(half_full));
  // R7: almost-empty held through setup and the edge after it
  p_ae_hold_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    (state == RT_SETUP || pc == 2'd2) |=> $stable(almost_empty));
endmodule

// File: rtl/rr_fifo.sv
module rr_fifo #(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int AE_OFF      = 2,
  parameter int AF_OFF      = 3,
  parameter int SETUP_CYC   = 4,
  parameter int RELEASE_CYC = 14
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          almost_full,
  input  logic          rd_en,
  input  logic          rt_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          half_full,
  output logic          almost_empty
);
  localparam int DEPTH = 1 << AW;

  logic          wrst_n, rrst_n, wr_do, busy, hold, busy_s, hold_s;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q;

  rr_sync #(.W(1)) u_wrst (.clk(wclk), .rst_n(rst_n), .d(1'b1), .q(wrst_n));
  rr_sync #(.W(1)) u_rrst (.clk(rclk), .rst_n(rst_n), .d(1'b1), .q(rrst_n));

  rr_sync #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  rr_sync #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  rr_sync #(.W(2))    u_ctl (.clk(wclk), .rst_n(wrst_n), .d({busy, hold}),
                             .q({busy_s, hold_s}));

  always_ff @(posedge wclk) begin
    if (wr_do) mem[waddr] <= wr_data;
  end
  assign mem_q = mem[raddr];

  rr_wr_side #(.AW(AW), .AF_OFF(AF_OFF), .RELEASE_CYC(RELEASE_CYC)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .busy_s(busy_s), .hold_s(hold_s), .waddr(waddr), .wr_do(wr_do),
    .wgray(wgray), .wr_ready(wr_ready), .almost_full(almost_full)
  );

  rr_rd_side #(.DW(DW), .AW(AW), .AE_OFF(AE_OFF), .SETUP_CYC(SETUP_CYC)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rt_req(rt_req),
    .wgray_s(wgray_s), .mem_q(mem_q), .raddr(raddr), .rgray(rgray),
    .rd_data(rd_data), .rd_valid(rd_valid), .half_full(half_full),
    .almost_empty(almost_empty), .busy(busy), .hold(hold)
  );
endmodule

// File: tb/tb_rr_fifo.sv
module tb_rr_fifo;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, rd_en, rt_req;
  logic [7:0] wr_data;
  logic       wr_ready, almost_full, rd_valid, half_full, almost_empty;
  logic [7:0] rd_data;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rr_fifo dut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ready(wr_ready), .almost_full(almost_full), .rd_en(rd_en),
    .rt_req(rt_req), .rd_data(rd_data), .rd_valid(rd_valid),
    .half_full(half_full), .almost_empty(almost_empty)
  );

  // fields: fill count[8:4], half_full, almost_empty, almost_full, wr_ready (R11, R2)
  localparam logic [8:0] VEC [0:9] = '{
    {5'd0,  4'b0101}, {5'd1,  4'b0101}, {5'd2,  4'b0101}, {5'd3,  4'b0001},
    {5'd8,  4'b0001}, {5'd9,  4'b1001}, {5'd13, 4'b1001}, {5'd14, 4'b1011},
    {5'd16, 4'b1011}, {5'd17, 4'b1010}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rt_req = 1'b0; wr_data = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
  endtask

  task automatic push(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_data = base + 8'(i);
      tick();
    end
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R11 reset rd_valid", rd_valid, 0);
    chk("R11 reset wr_ready", wr_ready, 1);
    chk("R11 reset almost_empty", almost_empty, 1);
    chk("R11 reset half_full", half_full, 0);
    chk("R11 reset almost_full", almost_full, 0);

    // table walk: fill levels and flags
    for (int v = 0; v < 10; v++) begin
      do_reset();
      push(int'(VEC[v][8:4]), 8'h10);
      wait_n(8);
      chk("R11 half_full", half_full, VEC[v][3]);
      chk("R11 almost_empty", almost_empty, VEC[v][2]);
      chk("R11 almost_full", almost_full, VEC[v][1]);
      chk("R2 wr_ready", wr_ready, VEC[v][0]);
    end

    // R1 fall-through and order
    do_reset();
    push(5, 8'hA0);
    wait_n(6);
    chk("R1 first word shown", rd_valid, 1);
    for (int i = 0; i < 5; i++) begin
      chk("R1 order", rd_data, 8'hA0 + 8'(i));
      rd_en = 1'b1; tick();
    end
    rd_en = 1'b0;
    chk("R1 drained", rd_valid, 0);

    // R2 read strobe on empty has no effect
    rd_en = 1'b1; wait_n(2); rd_en = 1'b0;
    chk("R2 empty read", rd_valid, 0);
    push(1, 8'h3C);
    wait_n(6);
    chk("R2 after empty read valid", rd_valid, 1);
    chk("R2 after empty read data", rd_data, 8'h3C);
    rd_en = 1'b1; tick(); rd_en = 1'b0;

    // R2 write at full dropped
    do_reset();
    push(17, 8'h40);
    wait_n(6);
    chk("R2 full ready low", wr_ready, 0);
    push(1, 8'hEE);
    wait_n(6);
    for (int i = 0; i < 17; i++) begin
      chk("R2 full drain", rd_data, 8'h40 + 8'(i));
      rd_en = 1'b1; tick();
    end
    rd_en = 1'b0;
    chk("R2 extra write dropped", rd_valid, 0);

    // retransmit with 14 stored words
    do_reset();
    push(14, 8'h01);
    wait_n(8);
    for (int i = 0; i < 12; i++) begin
      rd_en = 1'b1; tick();
    end
    rd_en = 1'b0;
    wait_n(3);
    chk("R5 pre-rt data", rd_data, 8'h0D);
    chk("R7 pre-rt almost_empty", almost_empty, 1);
    chk("R6 pre-rt half_full", half_full, 0);
    chk("R8 pre-rt almost_full", almost_full, 0);
    rt_req = 1'b1; tick();                 // accepting edge A
    rt_req = 1'b0;
    chk("R3 valid drops", rd_valid, 0);
    rd_en = 1'b1; rt_req = 1'b1; tick();   // A+1, second strobe ignored
    rt_req = 1'b0;
    chk("R3 setup valid", rd_valid, 0);
    chk("R6 hf held", half_full, 0);
    tick();                                // A+2
    chk("R10 wr_ready in setup", wr_ready, 1);
    wr_en = 1'b1; wr_data = 8'h77; tick(); // A+3, write dropped
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R3 setup valid late", rd_valid, 0);
    chk("R6 hf held late", half_full, 0);
    chk("R10 wr_ready late", wr_ready, 1);
    tick();                                // A+4 final edge
    chk("R4 final valid", rd_valid, 1);
    chk("R4 final data", rd_data, 8'h01);
    chk("R6 hf refreshed", half_full, 1);
    chk("R7 ae held at final", almost_empty, 1);
    tick();                                // F+1
    chk("R7 ae held F+1", almost_empty, 1);
    chk("R8 af held F+1", almost_full, 0);
    chk("R5 no strobe no advance", rd_data, 8'h01);
    tick();                                // F+2
    chk("R7 ae refreshed", almost_empty, 0);
    chk("R8 af held F+2", almost_full, 0);
    tick();                                // F+3
    chk("R8 af refreshed", almost_full, 1);
    for (int i = 0; i < 14; i++) begin
      chk("R5 replay order", rd_data, 8'h01 + 8'(i));
      rd_en = 1'b1; tick();
    end
    rd_en = 1'b0;
    chk("R9 blocked write absent", rd_valid, 0);
    push(1, 8'h99);
    wait_n(6);
    chk("R9 writes resumed", rd_data, 8'h99);

    // R9 timeout release on an empty retransmit
    do_reset();
    rt_req = 1'b1; tick();                 // A
    rt_req = 1'b0;
    wait_n(12);                            // A+12
    chk("R4 empty setup no word", rd_valid, 0);
    wr_en = 1'b1; wr_data = 8'h55; tick(); // A+13 dropped
    wr_data = 8'h66; tick();               // A+14 accepted
    wr_en = 1'b0;
    wait_n(6);
    chk("R9 timeout valid", rd_valid, 1);
    chk("R9 timeout data", rd_data, 8'h66);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R9 only one word", rd_valid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule